// File: doc/BRIEF.md
# Two-Level Saturating Sample Accumulator

This block totals a stream of signed per-sample values, one total per channel, over a fixed-length accumulation interval. It does this in two stages. An inner stage adds a programmable number of consecutive valid samples. An outer stage adds a programmable number of those inner totals. When the last sample of an interval arrives, the outer totals are copied into holding registers. At the same time both stages restart from zero and an interrupt flag is raised. The processor then has a whole interval to read the stable totals and clear the flag.

The inner length comes from a 2-bit selector. The outer count is a plain register. Each interval uses the settings in force when its first sample arrives. All arithmetic clamps at the signed 32-bit limits and never wraps. Samples arrive on a valid strobe and may have gaps of any length between them.

Top module: `dual_stage_accum`

## Requirements
- R1: While reset is held and right after it is released, every holding register reads 0 and `irq` reads 0.
- R2: The inner stage closes after PRE_UNIT × 2^`pre_sel` valid samples. With `pre_sel` values 0, 1, 2 and 3 this is 1, 2, 4 and 8 times PRE_UNIT.
- R3: One interval holds (inner length) × `sum_cyc` valid samples. A `sum_cyc` of 0 acts as 1.
- R4: In the cycle after the last sample of an interval, each channel's holding register shows the total of that interval's samples. Both stages then start again from zero, so no sample is counted in two intervals.
- R5: `irq` becomes 1 in the same cycle that the holding registers update.
- R6: `irq` stays at 1 until a cycle in which `irq_clr` is high. If `irq_clr` is high in the same cycle that an interval ends, `irq` stays 1.
- R7: The holding registers do not change between interval ends.
- R8: Each inner total and each outer total is clamped to the range 0x80000000..0x7FFFFFFF, and it leaves a limit only when later samples move it back into range.
- R9: An interval uses the `pre_sel` and `sum_cyc` values present with its first sample. Changes made later in the interval take effect from the next interval.
- R10: While `smp_valid` is low, `smp_data` has no effect.
- R11: Each channel accumulates only its own field of `smp_data`. Channel k occupies bits [k×SW +: SW], and its total appears at `sum_out[k×32 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | NCH×SW | Signed samples, one field per channel |
| pre_sel | input | 2 | Inner-stage length selector |
| sum_cyc | input | CW | Inner totals per interval (0 acts as 1) |
| irq_clr | input | 1 | Clears the interrupt flag |
| sum_out | output | NCH×32 | Latched signed interval totals |
| irq | output | 1 | Interval-complete interrupt flag |

## Verification
The assertions take for granted that samples are at most 32 bits wide, so that sign extension into an accumulator never loses information. They also take for granted that `irq_clr` is the only thing that lowers the flag. The stimulus keeps SW at 32 and drives each configuration register at a falling edge. The bench sweeps every selector value against outer counts 0 to 3, inserting gaps between samples filled with junk data. It also runs cases pinned at both 32-bit limits, a case that changes the configuration mid-interval, and a case that clears the flag in the same cycle an interval ends.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int ACC_W = 32;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    logic [ACC_W:0] t;
    t = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (t[ACC_W] != t[ACC_W-1])
      sat_add = t[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else
      sat_add = t[ACC_W-1:0];
  endfunction
endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl #(
  parameter int CW       = 8,
  parameter int PRE_UNIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [1:0]    pre_sel,
  input  logic [CW-1:0] sum_cyc,
  input  logic          irq_clr,
  output logic          pre_last,
  output logic          int_last,
  output logic          irq
);
  localparam int PIW = $clog2(PRE_UNIT * 8 + 1);

  logic [PIW-1:0] pre_idx_q, pre_idx_d;
  logic [CW-1:0]  cyc_idx_q, cyc_idx_d;
  logic [1:0]     act_sel_q, act_sel_d;
  logic [CW-1:0]  act_cyc_q, act_cyc_d;
  logic           irq_q, irq_d;
  logic           at_start;
  logic [1:0]     eff_sel;
  logic [CW-1:0]  eff_cyc;
  logic [PIW-1:0] pre_len;

  always_comb begin
    at_start = (pre_idx_q == '0) && (cyc_idx_q == '0);
    eff_sel  = at_start ? pre_sel : act_sel_q;
    if (at_start)
      eff_cyc = (sum_cyc == '0) ? CW'(1) : sum_cyc;
    else
      eff_cyc = act_cyc_q;
    pre_len  = PIW'(PRE_UNIT) << eff_sel;
    pre_last = (pre_idx_q == pre_len - PIW'(1));
    int_last = pre_last && (cyc_idx_q == eff_cyc - CW'(1));
  end

  always_comb begin
    pre_idx_d = pre_idx_q;
    cyc_idx_d = cyc_idx_q;
    act_sel_d = act_sel_q;
    act_cyc_d = act_cyc_q;
    if (smp_valid) begin
      if (at_start) begin
        act_sel_d = eff_sel;
        act_cyc_d = eff_cyc;
      end
      if (pre_last) begin
        pre_idx_d = '0;
        cyc_idx_d = int_last ? '0 : cyc_idx_q + CW'(1);
      end else begin
        pre_idx_d = pre_idx_q + PIW'(1);
      end
    end
    if (smp_valid && int_last)
      irq_d = 1'b1;
    else if (irq_clr)
      irq_d = 1'b0;
    else
      irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_idx_q <= '0;
      cyc_idx_q <= '0;
      act_sel_q <= '0;
      act_cyc_q <= CW'(1);
      irq_q     <= 1'b0;
    end else begin
      pre_idx_q <= pre_idx_d;
      cyc_idx_q <= cyc_idx_d;
      act_sel_q <= act_sel_d;
      act_cyc_q <= act_cyc_d;
      irq_q     <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_IRQ_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && int_last) |=> irq_q); // R5
  AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |=> ($stable(act_sel_q) && $stable(act_cyc_q))); // R9
  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |-> (pre_idx_q < pre_len)); // R2
endmodule

// File: rtl/accum_lane.sv
module accum_lane
  import accum_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pre_last,
  input  logic             int_last,
  input  logic [SW-1:0]    smp,
  output logic [ACC_W-1:0] hold_o
);
  logic signed [SW-1:0]    s_raw;
  logic [ACC_W-1:0]        s_ext;
  logic [ACC_W-1:0]        pre_q, pre_d, fin_q, fin_d, hold_q, hold_d;
  logic [ACC_W-1:0]        pre_new, fin_new;

  assign s_raw = smp;
  assign s_ext = ACC_W'(s_raw);

  always_comb begin
    pre_new = sat_add(pre_q, s_ext);
    fin_new = sat_add(fin_q, pre_new);
    pre_d   = pre_q;
    fin_d   = fin_q;
    hold_d  = hold_q;
    if (en) begin
      if (pre_last) begin
        pre_d = '0;
        if (int_last) begin
          fin_d  = '0;
          hold_d = fin_new;
        end else begin
          fin_d = fin_new;
        end
      end else begin
        pre_d = pre_new;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      fin_q  <= '0;
      hold_q <= '0;
    end else begin
      pre_q  <= pre_d;
      fin_q  <= fin_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && pre_last && int_last) |=> $stable(hold_q)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pre_last && !pre_q[ACC_W-1] && !s_ext[ACC_W-1]) |=> !pre_q[ACC_W-1]); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pre_last && pre_q[ACC_W-1] && s_ext[ACC_W-1]) |=> pre_q[ACC_W-1]); // R8
  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pre_q) && $stable(fin_q))); // R10
endmodule

// File: rtl/dual_stage_accum.sv
module dual_stage_accum
  import accum_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int SW       = 24,
  parameter int CW       = 8,
  parameter int PRE_UNIT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [NCH*SW-1:0]    smp_data,
  input  logic [1:0]           pre_sel,
  input  logic [CW-1:0]        sum_cyc,
  input  logic                 irq_clr,
  output logic [NCH*ACC_W-1:0] sum_out,
  output logic                 irq
);
  logic pre_last, int_last;

  accum_ctrl #(.CW(CW), .PRE_UNIT(PRE_UNIT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .pre_sel   (pre_sel),
    .sum_cyc   (sum_cyc),
    .irq_clr   (irq_clr),
    .pre_last  (pre_last),
    .int_last  (int_last),
    .irq       (irq)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    accum_lane #(.SW(SW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (smp_valid),
      .pre_last (pre_last),
      .int_last (int_last),
      .smp      (smp_data[k*SW +: SW]),
      .hold_o   (sum_out[k*ACC_W +: ACC_W])
    );
  end

  AST_SUM_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !$stable(sum_out)) |-> 1'b0); // R5
endmodule

// File: tb/dual_stage_accum_bench.sv
module dual_stage_accum_bench;
  localparam int NCH = 2;
  localparam int SW  = 32;
  localparam int CW  = 4;
  localparam int PU  = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, smp_valid, irq_clr, irq;
  logic [NCH*SW-1:0] smp_data;
  logic [1:0]        pre_sel;
  logic [CW-1:0]     sum_cyc;
  logic [NCH*32-1:0] sum_out;

  int total = 0;
  int bad   = 0;
  longint exp_h [NCH];

  dual_stage_accum #(.NCH(NCH), .SW(SW), .CW(CW), .PRE_UNIT(PU)) u_dual_stage_accum (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .pre_sel(pre_sel), .sum_cyc(sum_cyc), .irq_clr(irq_clr),
    .sum_out(sum_out), .irq(irq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint gen(input int ch, input int i, input int mode);
    if (mode == 1) return (ch == 0) ? 64'sd2147483647 : -64'sd2147483648;
    if (mode == 2) begin
      if (ch == 0) return (i < 3) ? 64'sd2147483647 : -64'sd1000;
      return (i < 3) ? -64'sd2147483648 : 64'sd1000;
    end
    return (ch == 0) ? longint'(i * 3 - 11) : longint'(7 - i * 5 + ch);
  endfunction

  function automatic longint rd(input int ch);
    return longint'($signed(sum_out[ch*32 +: 32]));
  endfunction

  task automatic run_iv(input int sel, input int cyc, input int mode,
                        input int alt_sel, input int alt_cyc, input bit swap,
                        input bit clr_at_end, input string tag);
    int len, nc, n;
    longint ef [NCH];
    len = PU << sel;
    nc  = (cyc == 0) ? 1 : cyc;
    n   = len * nc;
    for (int ch = 0; ch < NCH; ch++) begin
      longint fin;
      fin = 0;
      for (int c = 0; c < nc; c++) begin
        longint pre;
        pre = 0;
        for (int p = 0; p < len; p++) pre = sat(pre + gen(ch, c * len + p, mode));
        fin = sat(fin + pre);
      end
      ef[ch] = fin;
    end
    pre_sel = 2'(sel);
    sum_cyc = CW'(cyc);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) begin
        for (int ch = 0; ch < NCH; ch++) chk({"R7 hold mid ", tag}, rd(ch), exp_h[ch]);
        chk({"R3 no early irq ", tag}, longint'(irq), 0);
      end
      smp_valid = 1'b1;
      for (int ch = 0; ch < NCH; ch++) smp_data[ch*SW +: SW] = SW'(gen(ch, i, mode));
      irq_clr = clr_at_end && (i == n - 1);
      @(negedge clk);
      smp_valid = 1'b0;
      irq_clr   = 1'b0;
      smp_data  = {NCH{32'h5A5A_7777}};
      if (swap && i == 0) begin
        pre_sel = 2'(alt_sel);
        sum_cyc = CW'(alt_cyc);
      end
      if (i % 3 == 2) @(negedge clk); // R10 gap with junk data
    end
    chk({"R5 irq set ", tag}, longint'(irq), 1);
    for (int ch = 0; ch < NCH; ch++) chk({"R4 R11 sum ", tag}, rd(ch), ef[ch]);
    exp_h = ef;
    repeat (2) @(negedge clk);
    chk({"R6 irq held ", tag}, longint'(irq), 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk({"R6 irq cleared ", tag}, longint'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; irq_clr = 1'b0;
    smp_data = '0; pre_sel = '0; sum_cyc = '0;
    for (int ch = 0; ch < NCH; ch++) exp_h[ch] = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", longint'(irq), 0);
    for (int ch = 0; ch < NCH; ch++) chk("R1 sum in reset", rd(ch), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", longint'(irq), 0);
    for (int ch = 0; ch < NCH; ch++) chk("R1 sum after reset", rd(ch), 0);

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 4; c++)
        run_iv(s, c, 0, 0, 0, 1'b0, 1'b0, "R2 R3 sweep");

    run_iv(1, 2, 1, 0, 0, 1'b0, 1'b0, "R8 pinned");
    run_iv(0, 4, 2, 0, 0, 1'b0, 1'b0, "R8 recover");
    run_iv(2, 3, 2, 0, 0, 1'b0, 1'b0, "R8 inner");
    run_iv(1, 2, 0, 3, 5, 1'b1, 1'b0, "R9 mid change");
    run_iv(3, 5, 0, 0, 0, 1'b0, 1'b0, "R9 next interval");
    run_iv(0, 3, 0, 0, 0, 1'b0, 1'b1, "R6 clear collides");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule